// File: doc/BRIEF.md
# Exception and Interrupt Control Coprocessor

This unit is the system-control block of a small 32-bit RISC core. It keeps the processor's trap state: a status word with a global enable, an exception-level flag and an eight-level interrupt mask. It also holds a cause word with the pending levels and the last exception code, the saved return address, the faulting address of the last addressing fault, and a free-running count/compare timer. The pipeline moves words in and out of these registers by register number. It reports synchronous exceptions, the return-from-exception instruction and the address of the instruction about to execute.

Each cycle the unit decides whether control leaves the normal flow. When it does, it raises `redirect` with a target address in the same cycle, and its own state is updated at the next clock edge. An exception or an accepted interrupt sends the core to a fixed handler vector. A return sends it back to the saved address. The exception level both blocks further interrupts and protects the saved address. Interrupt level 5 is shared between an external line and the built-in timer.

All pins are plain control and status signals sampled on every clock. No stream carries data through the block, so there is no valid/ready handshake and no back-pressure. The pipeline must act on `redirect` in the cycle it is shown.

Top module: `trap_ctrl_unit`

## Requirements
- R1: After reset, the status word reads 0x0000_0010, the cause word, saved PC, fault address and timer compare read 0, and `redirect` is low.
- R2: Register numbers: 8 fault address, 9 count, 11 compare, 12 status, 13 cause, 14 saved PC. Any other number reads 0. Status layout: bits 15:8 are the interrupt mask (level n at bit 8+n), bit 1 is the exception level (EXL), bit 0 is the global enable, and bit 4 always reads 1. All other bits read 0. Saved PC and compare read back what was written.
- R3: Cause bits 15:8 show pending level n at bit 8+n whether or not it is masked. Levels 0 and 1 are set by software through cause bits 9:8. Levels 2 to 7 follow `ext_irq[0]` to `ext_irq[5]`. Level 5 is also set by the timer. Cause bits 6:2 hold a writable exception code. Writing 0 to the cause word clears the software levels and the code, while the external levels keep following their lines.
- R4: An interrupt is accepted when the global enable is 1, EXL is 0 and some pending level is also enabled in the mask. In that cycle `redirect` is high and `redirect_pc` is 0x8000_0180.
- R5: When an interrupt is accepted, the next edge stores `cur_pc` into the saved PC, sets EXL and writes exception code 0.
- R6: While EXL is 1, no interrupt is accepted and the saved PC is not overwritten except by a software write. Exceptions are still redirected and still record their code.
- R7: A pipeline exception (`exc_valid`) redirects to 0x8000_0180. It records `exc_code` in the cause word and sets EXL. It saves `cur_pc` only if EXL was 0. When `exc_addr_valid` is high it loads `exc_addr` into the fault address register. Software writes to the fault address register are ignored.
- R8: `eret` redirects to the saved PC in the same cycle and clears EXL at the next edge.
- R9: Priority is exception, then interrupt, then return. A trap's update of status or cause overrides a software write to the same register in the same cycle.
- R10: Count increments by one every `TICK_CYCLES` clocks. A software write loads Count and restarts the tick period.
- R11: When Count steps onto the Compare value, the timer's level-5 pending bit sets. Writing Compare clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mt_en | input | 1 | Software write strobe |
| mt_sel | input | 5 | Register number for the write |
| mt_wdata | input | 32 | Write data |
| mf_sel | input | 5 | Register number for the read |
| mf_rdata | output | 32 | Read data (combinational) |
| ext_irq | input | 6 | External interrupt lines for levels 2 to 7 |
| exc_valid | input | 1 | Pipeline exception this cycle |
| exc_code | input | 5 | Code of that exception |
| exc_addr_valid | input | 1 | Exception carries a faulting address |
| exc_addr | input | 32 | Faulting address |
| eret | input | 1 | Return-from-exception executes this cycle |
| cur_pc | input | 32 | Address of the instruction about to execute |
| redirect | output | 1 | PC must be replaced this cycle |
| redirect_pc | output | 32 | Replacement PC |

## Verification
The bench checks the interlock between EXL and the saved PC. It raises an exception while a handler is already running. A design that saves the PC regardless would lose the original return address, and a design that blocks all traps under EXL would ignore the fault. It shows a pending level that is masked, and a design that gates the cause bits by the mask would hide it. It checks that clearing the cause word drops a software interrupt without touching the external lines. It checks that exception and return in the same cycle go to the vector. It counts timer cycles exactly, so an off-by-one in the tick period or the compare match moves the timer interrupt by a full period and is caught.

// File: rtl/trap_ctrl_pkg.sv
package trap_ctrl_pkg;

  localparam int NUM_LEVELS = 8;

  typedef enum logic [4:0] {
    SEL_BADADDR = 5'd8,
    SEL_COUNT   = 5'd9,
    SEL_COMPARE = 5'd11,
    SEL_STATUS  = 5'd12,
    SEL_CAUSE   = 5'd13,
    SEL_EPC     = 5'd14
  } cp_sel_e;

  typedef enum logic [1:0] {
    EV_NONE,
    EV_EXC,
    EV_IRQ,
    EV_RET
  } trap_ev_e;

endpackage

// File: rtl/trap_timer.sv
module trap_timer #(
  parameter int TICK_CYCLES = 1000,
  parameter int W           = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cnt_wr,
  input  logic         cmp_wr,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] count,
  output logic [W-1:0] compare,
  output logic         pend
);

  localparam int PW = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;

  logic [PW-1:0] presc;
  logic          tick;
  logic [W-1:0]  count_inc;

  assign tick      = (presc == PW'(TICK_CYCLES - 1));
  assign count_inc = count + W'(1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      presc <= '0;
      count <= '0;
    end else if (cnt_wr) begin
      presc <= '0;
      count <= wdata;
    end else if (tick) begin
      presc <= '0;
      count <= count_inc;
    end else begin
      presc <= presc + PW'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      compare <= '0;
      pend    <= 1'b0;
    end else begin
      if (cmp_wr) begin
        compare <= wdata;
        pend    <= 1'b0;
      end else if (tick && !cnt_wr && (count_inc == compare)) begin
        pend <= 1'b1;
      end
    end
  end

  // R11: compare write drops the timer request
  a_r11_cmp_clears: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_wr |=> !pend);

  // R10: count only moves on a tick or a write
  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && !tick) |=> $stable(count));

  a_r10_step: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_wr && tick) |=> (count == $past(count) + W'(1)));

endmodule

// File: rtl/trap_prio.sv
module trap_prio
  import trap_ctrl_pkg::*;
#(
  parameter int LEVELS = NUM_LEVELS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exc_valid,
  input  logic              eret,
  input  logic              ie,
  input  logic              exl,
  input  logic [LEVELS-1:0] pending,
  input  logic [LEVELS-1:0] mask,
  output trap_ev_e          ev
);

  logic irq_ok;

  assign irq_ok = ie && !exl && (|(pending & mask));

  always_comb begin
    if (exc_valid)   ev = EV_EXC;
    else if (irq_ok) ev = EV_IRQ;
    else if (eret)   ev = EV_RET;
    else             ev = EV_NONE;
  end

  // R6: no interrupt accepted under the exception level
  a_r6_exl_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    exl |-> (ev != EV_IRQ));

  // R9: an exception always wins
  a_r9_exc_first: assert property (@(posedge clk) disable iff (!rst_n)
    exc_valid |-> (ev == EV_EXC));

endmodule

// File: rtl/trap_ctrl_unit.sv
module trap_ctrl_unit
  import trap_ctrl_pkg::*;
#(
  parameter int          TICK_CYCLES = 1000,
  parameter int          SW_LEVELS   = 2,
  parameter int          TIMER_LEVEL = 5,
  parameter logic [31:0] VECTOR      = 32'h8000_0180
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        mt_en,
  input  logic [4:0]  mt_sel,
  input  logic [31:0] mt_wdata,
  input  logic [4:0]  mf_sel,
  output logic [31:0] mf_rdata,
  input  logic [5:0]  ext_irq,
  input  logic        exc_valid,
  input  logic [4:0]  exc_code,
  input  logic        exc_addr_valid,
  input  logic [31:0] exc_addr,
  input  logic        eret,
  input  logic [31:0] cur_pc,
  output logic        redirect,
  output logic [31:0] redirect_pc
);

  localparam int HW_LEVELS = NUM_LEVELS - SW_LEVELS;

  logic [NUM_LEVELS-1:0] st_mask;
  logic                  st_exl;
  logic                  st_ie;
  logic [SW_LEVELS-1:0]  sw_pend;
  logic [4:0]            cause_code;
  logic [31:0]           epc_q;
  logic [31:0]           badaddr_q;
  logic [31:0]           count_q;
  logic [31:0]           compare_q;
  logic                  tmr_pend;
  logic [NUM_LEVELS-1:0] pend_all;
  logic [NUM_LEVELS-1:0] tmr_vec;
  logic                  wr_status, wr_cause, wr_epc, wr_count, wr_compare;
  trap_ev_e              ev;

  assign wr_status  = mt_en && (mt_sel == SEL_STATUS);
  assign wr_cause   = mt_en && (mt_sel == SEL_CAUSE);
  assign wr_epc     = mt_en && (mt_sel == SEL_EPC);
  assign wr_count   = mt_en && (mt_sel == SEL_COUNT);
  assign wr_compare = mt_en && (mt_sel == SEL_COMPARE);

  always_comb begin
    tmr_vec = '0;
    tmr_vec[TIMER_LEVEL] = tmr_pend;
  end

  assign pend_all = {ext_irq[HW_LEVELS-1:0], sw_pend} | tmr_vec;

  trap_timer #(
    .TICK_CYCLES (TICK_CYCLES),
    .W           (32)
  ) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_wr  (wr_count),
    .cmp_wr  (wr_compare),
    .wdata   (mt_wdata),
    .count   (count_q),
    .compare (compare_q),
    .pend    (tmr_pend)
  );

  trap_prio #(
    .LEVELS (NUM_LEVELS)
  ) u_prio (
    .clk       (clk),
    .rst_n     (rst_n),
    .exc_valid (exc_valid),
    .eret      (eret),
    .ie        (st_ie),
    .exl       (st_exl),
    .pending   (pend_all),
    .mask      (st_mask),
    .ev        (ev)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_mask    <= '0;
      st_exl     <= 1'b0;
      st_ie      <= 1'b0;
      sw_pend    <= '0;
      cause_code <= '0;
      epc_q      <= '0;
      badaddr_q  <= '0;
    end else begin
      if (wr_status) begin
        st_mask <= mt_wdata[15:8];
        st_exl  <= mt_wdata[1];
        st_ie   <= mt_wdata[0];
      end
      if (wr_cause) begin
        sw_pend    <= mt_wdata[8 +: SW_LEVELS];
        cause_code <= mt_wdata[6:2];
      end
      if (wr_epc) epc_q <= mt_wdata;
      case (ev)
        EV_EXC: begin
          st_exl     <= 1'b1;
          cause_code <= exc_code;
          if (!st_exl) epc_q <= cur_pc;
          if (exc_addr_valid) badaddr_q <= exc_addr;
        end
        EV_IRQ: begin
          st_exl     <= 1'b1;
          cause_code <= 5'd0;
          epc_q      <= cur_pc;
        end
        EV_RET: st_exl <= 1'b0;
        default: ;
      endcase
    end
  end

  always_comb begin
    redirect    = (ev != EV_NONE);
    redirect_pc = (ev == EV_RET) ? epc_q : VECTOR;
  end

  always_comb begin
    mf_rdata = '0;
    case (mf_sel)
      SEL_BADADDR: mf_rdata = badaddr_q;
      SEL_COUNT:   mf_rdata = count_q;
      SEL_COMPARE: mf_rdata = compare_q;
      SEL_STATUS:  mf_rdata = {16'd0, st_mask, 3'd0, 1'b1, 2'd0, st_exl, st_ie};
      SEL_CAUSE:   mf_rdata = {16'd0, pend_all, 1'b0, cause_code, 2'd0};
      SEL_EPC:     mf_rdata = epc_q;
      default:     mf_rdata = '0;
    endcase
  end

  // R5: accepted interrupt saves the PC and enters the exception level
  a_r5_irq_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_IRQ) |=> (epc_q == $past(cur_pc)) && st_exl && (cause_code == 5'd0));

  // R6: saved PC is frozen under the exception level
  a_r6_epc_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (st_exl && !wr_epc) |=> $stable(epc_q));

  // R7: exception records its code and enters the exception level
  a_r7_exc_entry: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_EXC) |=> st_exl && (cause_code == $past(exc_code)));

  // R8: return leaves the exception level
  a_r8_ret_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ev == EV_RET) |=> !st_exl);

  // R2: user-mode bit always reads one
  a_r2_user_bit: assert property (@(posedge clk) disable iff (!rst_n)
    (mf_sel == SEL_STATUS) |-> mf_rdata[4]);

endmodule

// File: tb/test_trap_ctrl_unit.sv
module test_trap_ctrl_unit;

  localparam int          TICK = 4;
  localparam logic [31:0] VEC  = 32'h8000_0180;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mt_en = 1'b0;
  logic [4:0]  mt_sel = '0;
  logic [31:0] mt_wdata = '0;
  logic [4:0]  mf_sel = '0;
  logic [31:0] mf_rdata;
  logic [5:0]  ext_irq = '0;
  logic        exc_valid = 1'b0;
  logic [4:0]  exc_code = '0;
  logic        exc_addr_valid = 1'b0;
  logic [31:0] exc_addr = '0;
  logic        eret = 1'b0;
  logic [31:0] cur_pc = '0;
  logic        redirect;
  logic [31:0] redirect_pc;

  int nchk  = 0;
  int nfail = 0;
  bit done  = 0;

  always #5 clk = ~clk;

  trap_ctrl_unit #(.TICK_CYCLES(TICK)) i_trap_ctrl_unit (
    .clk(clk), .rst_n(rst_n), .mt_en(mt_en), .mt_sel(mt_sel), .mt_wdata(mt_wdata),
    .mf_sel(mf_sel), .mf_rdata(mf_rdata), .ext_irq(ext_irq), .exc_valid(exc_valid),
    .exc_code(exc_code), .exc_addr_valid(exc_addr_valid), .exc_addr(exc_addr),
    .eret(eret), .cur_pc(cur_pc), .redirect(redirect), .redirect_pc(redirect_pc)
  );

  // {register number, write data, expected read-back}
  localparam logic [68:0] TAB [9] = '{
    {5'd12, 32'hFFFF_FFFF, 32'h0000_FF13},
    {5'd13, 32'hFFFF_FFFF, 32'h0000_037C},
    {5'd13, 32'h0000_0000, 32'h0000_0000},
    {5'd12, 32'h0000_0302, 32'h0000_0312},
    {5'd12, 32'h0000_0000, 32'h0000_0010},
    {5'd14, 32'h1234_5678, 32'h1234_5678},
    {5'd8,  32'hFFFF_FFFF, 32'h0000_0000},
    {5'd11, 32'h0000_ABCD, 32'h0000_ABCD},
    {5'd3,  32'hFFFF_FFFF, 32'h0000_0000}
  };

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] sel, input logic [31:0] d);
    @(negedge clk);
    mt_en = 1'b1; mt_sel = sel; mt_wdata = d;
    @(posedge clk); #1;
    mt_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [4:0] sel, input logic [31:0] exp, input string tag);
    @(negedge clk);
    mf_sel = sel; #1;
    check(mf_rdata, exp, tag);
  endtask

  task automatic ret_pulse(input logic [31:0] exp_pc, input string tag);
    @(negedge clk);
    eret = 1'b1; #1;
    check({31'd0, redirect}, 32'd1, tag);
    check(redirect_pc, exp_pc, tag);
    @(posedge clk); #1;
    eret = 1'b0;
  endtask

  initial begin
    #(10 * 100000);
    nfail++;
    $display("FAIL watchdog actual timeout expected completion");
    if (!done) begin
      $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
      $finish;
    end
  end

  initial begin
    bit early;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1 reset state
    rd_chk(5'd12, 32'h0000_0010, "R1 status");
    rd_chk(5'd13, 32'h0, "R1 cause");
    rd_chk(5'd14, 32'h0, "R1 epc");
    rd_chk(5'd11, 32'h0, "R1 compare");
    check({31'd0, redirect}, 32'd0, "R1 redirect");

    // R2 R3 R7 register table
    for (int i = 0; i < 9; i++) begin
      wr(TAB[i][68:64], TAB[i][63:32]);
      rd_chk(TAB[i][68:64], TAB[i][31:0], $sformatf("R2 table row %0d", i));
      check({31'd0, redirect}, 32'd0, $sformatf("R4 table row %0d quiet", i));
    end

    // R4 R5 interrupt entry; level 3 pending but masked (R3)
    ext_irq = 6'b000011;
    cur_pc  = 32'h0040_0020;
    wr(5'd12, 32'h0000_0401);
    @(negedge clk); #1;
    check({31'd0, redirect}, 32'd1, "R4 irq redirect");
    check(redirect_pc, VEC, "R4 irq vector");
    rd_chk(5'd14, 32'h0040_0020, "R5 epc saved");
    check({31'd0, redirect}, 32'd0, "R6 exl blocks");
    rd_chk(5'd13, 32'h0000_0C00, "R3 masked pending shown");
    rd_chk(5'd12, 32'h0000_0413, "R5 exl set");

    // R6 R7 exception while EXL set
    @(negedge clk);
    cur_pc = 32'h0040_0100; exc_valid = 1'b1; exc_code = 5'd4;
    exc_addr_valid = 1'b1; exc_addr = 32'hDEAD_BEE0; #1;
    check({31'd0, redirect}, 32'd1, "R7 exc redirect");
    check(redirect_pc, VEC, "R7 exc vector");
    @(posedge clk); #1;
    exc_valid = 1'b0; exc_addr_valid = 1'b0;
    rd_chk(5'd14, 32'h0040_0020, "R6 epc frozen");
    rd_chk(5'd13, 32'h0000_0C10, "R7 code recorded");
    rd_chk(5'd8, 32'hDEAD_BEE0, "R7 fault address");

    // R9 exception and return together
    @(negedge clk);
    exc_valid = 1'b1; exc_code = 5'd6; eret = 1'b1; #1;
    check(redirect_pc, VEC, "R9 exc beats eret");
    @(posedge clk); #1;
    exc_valid = 1'b0; eret = 1'b0;
    rd_chk(5'd12, 32'h0000_0413, "R9 exl kept");

    // R8 return
    ext_irq = 6'b0;
    ret_pulse(32'h0040_0020, "R8 eret target");
    rd_chk(5'd12, 32'h0000_0411, "R8 exl cleared");
    check({31'd0, redirect}, 32'd0, "R4 nothing pending");

    // R7 exception with EXL clear
    @(negedge clk);
    cur_pc = 32'h0040_0200; exc_valid = 1'b1; exc_code = 5'd5;
    @(posedge clk); #1;
    exc_valid = 1'b0;
    rd_chk(5'd14, 32'h0040_0200, "R7 epc saved");
    rd_chk(5'd8, 32'hDEAD_BEE0, "R7 fault address kept");
    rd_chk(5'd13, 32'h0000_0014, "R7 code 5");
    ret_pulse(32'h0040_0200, "R8 eret second");

    // R3 software interrupt and clear
    wr(5'd12, 32'h0000_0101);
    wr(5'd13, 32'h0000_0100);
    @(negedge clk); #1;
    check({31'd0, redirect}, 32'd1, "R3 sw irq taken");
    rd_chk(5'd13, 32'h0000_0100, "R5 code zero");
    wr(5'd13, 32'h0);
    rd_chk(5'd13, 32'h0, "R3 cause cleared");
    ret_pulse(32'h0040_0200, "R8 eret third");
    @(negedge clk); #1;
    check({31'd0, redirect}, 32'd0, "R3 sw level gone");

    // R10 R11 timer
    wr(5'd12, 32'h0000_2001);
    wr(5'd11, 32'd3);
    wr(5'd9, 32'd0);
    mf_sel = 5'd9;
    early = 0;
    for (int k = 1; k <= 13; k++) begin
      @(negedge clk); #1;
      if (k == 9) check(mf_rdata, 32'd2, "R10 count after 8 clocks");
      if (k <= 12 && redirect) early = 1;
      if (k == 13) check({31'd0, redirect}, 32'd1, "R11 timer irq");
    end
    check({31'd0, early}, 32'd0, "R11 not early");
    rd_chk(5'd13, 32'h0000_2000, "R11 level 5 pending");
    wr(5'd11, 32'd100);
    rd_chk(5'd13, 32'h0, "R11 compare write clears");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

endmodule